// File: doc/BRIEF.md
# Lane Bit Interleave and Field Insert Unit

This block is a vector bit-manipulation unit. It treats each of its three input vectors as sixteen lanes of 32 bits and applies one operation, chosen by an opcode, to every lane in parallel. Two operations merge the bits of two sources by interleaving them, either one bit from each source in turn or one bit from one source followed by two from the other. The third operation rotates a source lane left by an immediate count and writes a contiguous bit range of the rotated value into the destination lane. Destination bits outside that range keep their old values.

The operations are meant to be chained. Interleaving per-lane x and y texel coordinates one to one gives a Morton-order index. A field insert with a rotate of 4 and a field of bits 4 to 19 then turns that index into a byte offset within a fully swizzled 256x256 texture that has four 32-bit components per texel. The three-to-one interleave serves the same purpose for volume textures. The result is registered, so it appears one clock after the operands are presented.

Top module: `lane_bitmix`

## Requirements
- R1: While `rst_n` is low, `res_o` is all zeros at every clock edge.
- R2: Each result is registered. The operands present at a rising clock edge determine `res_o` after that edge. Opcode 0 (pass) copies `dst_i` to `res_o` unchanged.
- R3: Opcode 1 (pair interleave): in each lane, result bit 2i is bit i of `src_b_i`, and result bit 2i+1 is bit i of `src_a_i`, for i = 0 to 15.
- R4: For opcode 1, bits 16 to 31 of both sources in a lane have no effect on the result.
- R5: Opcode 2 (triple interleave): in each lane, result bit 3i is bit i of `src_b_i`, bit 3i+1 is bit 2i of `src_a_i`, and bit 3i+2 is bit 2i+1 of `src_a_i`. Positions at 32 or above are dropped, so bit 31 is bit 20 of `src_a_i`.
- R6: For opcode 2, bits 11 and above of `src_b_i` and bits 21 and above of `src_a_i` have no effect on the result.
- R7: Opcode 3 (field insert): each `src_a_i` lane is rotated left by `rot_i` modulo 32. Result bits `lo_i` through `hi_i` inclusive take the rotated bits at the same positions.
- R8: For opcode 3, result bits outside the field `lo_i`..`hi_i` equal the corresponding `dst_i` bits.
- R9: For opcode 3 with `lo_i` greater than `hi_i`, the result equals `dst_i`.
- R10: For opcode 3 with `lo_i` = 0 and `hi_i` = 31, the result is `src_a_i` rotated left by `rot_i`, whatever `dst_i` holds.
- R11: All lanes use the same opcode and immediates, and each lane's result depends only on that lane's operands.
- R12: A pair interleave of 8-bit coordinates (y on `src_a_i`, x on `src_b_i`) followed by a field insert of that result with rotate 4, field 4..19 and a zero destination gives 16 times the Morton index (x bit i at offset bit 4+2i, y bit i at offset bit 5+2i). Coordinate bits above bit 7 do not reach the offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 2 | Opcode: 0 pass, 1 pair interleave, 2 triple interleave, 3 field insert |
| src_a_i | input | 512 | First source vector, lane l at bits 32l+31..32l |
| src_b_i | input | 512 | Last source vector, same lane layout |
| dst_i | input | 512 | Current destination vector, same lane layout |
| rot_i | input | 5 | Left rotate count for field insert |
| lo_i | input | 5 | Lowest bit of the inserted field |
| hi_i | input | 5 | Highest bit of the inserted field |
| res_o | output | 512 | Registered result vector |

## Verification
Two situations are hard to reach with random stimulus. One is an empty field (low above high) or a full-word field, both of which sit at the edges of the immediate space. The other is an interleave source whose ignored upper bits differ while its used bits are the same. The stimulus builds these directly: it forces the immediates to the boundary values, and it replays an interleave with random garbage in the upper bits and compares the result to the one obtained from the clean operands. The texture-offset chain is reached by feeding the registered interleave result back as the source of a second, inserting operation in the following cycle.

// File: rtl/lane_bitmix_pkg.sv
// Shared definitions for the lane bit-mix unit.
// Assumes a two-bit opcode field on the top-level port.
package lane_bitmix_pkg;

    typedef enum logic [1:0] {
        MIX_PASS   = 2'd0,
        MIX_ILV11  = 2'd1,
        MIX_ILV21  = 2'd2,
        MIX_INSERT = 2'd3
    } mix_op_e;

endpackage

// File: rtl/lmx_interleave.sv
// Pure wiring for both interleave patterns within one lane.
// Assumes LW is even and at least 4; unused source bits are folded into a sink.
module lmx_interleave #(
    parameter int LW = 32
) (
    input  logic [LW-1:0] src_a,
    input  logic [LW-1:0] src_b,
    output logic [LW-1:0] ilv11,
    output logic [LW-1:0] ilv21
);
    localparam int NB21 = (LW + 2) / 3;
    localparam int NA21 = LW - NB21;

    logic unused_hi;

    // Sink for source bits no interleave pattern reaches.
    assign unused_hi = ^{src_a[LW-1:NA21], src_b[LW-1:LW/2]};

    genvar k;
    generate
        for (k = 0; k < LW; k++) begin : g_bit
            // Pair pattern: even positions from the last source.
            if (k % 2 == 0) begin : g_even
                assign ilv11[k] = src_b[k/2];
            end else begin : g_odd
                assign ilv11[k] = src_a[k/2];
            end
            // Triple pattern: one bit of the last source, two of the first.
            if (k % 3 == 0) begin : g_t0
                assign ilv21[k] = src_b[k/3];
            end else begin : g_t12
                assign ilv21[k] = src_a[2*(k/3) + (k%3) - 1];
            end
        end
    endgenerate

endmodule

// File: rtl/lmx_field_insert.sv
// Rotates one lane left and merges an inclusive bit range into the destination.
// Assumes lo greater than hi means an empty field.
module lmx_field_insert #(
    parameter  int LW  = 32,
    localparam int SHW = $clog2(LW)
) (
    input  logic [LW-1:0]  src,
    input  logic [LW-1:0]  dst,
    input  logic [SHW-1:0] rot,
    input  logic [SHW-1:0] lo,
    input  logic [SHW-1:0] hi,
    output logic [LW-1:0]  merged
);
    logic [2*LW-1:0] dbl;
    logic [LW-1:0]   rotated;
    logic [LW-1:0]   field;

    // Left rotate by shifting a doubled copy.
    assign dbl     = {src, src} << rot;
    assign rotated = dbl[2*LW-1:LW];

    // Per-bit window compare builds the field mask.
    always_comb begin
        for (int k = 0; k < LW; k++) begin
            field[k] = (k >= int'(lo)) && (k <= int'(hi));
        end
    end

    // Select rotated bits inside the field, destination bits elsewhere.
    assign merged = (rotated & field) | (dst & ~field);

endmodule

// File: rtl/lmx_lane.sv
// One lane: all three operations plus pass, selected by opcode.
// Assumes the opcode is shared by every lane.
module lmx_lane
    import lane_bitmix_pkg::*;
#(
    parameter  int LW  = 32,
    localparam int SHW = $clog2(LW)
) (
    input  mix_op_e        op,
    input  logic [LW-1:0]  src_a,
    input  logic [LW-1:0]  src_b,
    input  logic [LW-1:0]  dst,
    input  logic [SHW-1:0] rot,
    input  logic [SHW-1:0] lo,
    input  logic [SHW-1:0] hi,
    output logic [LW-1:0]  res
);
    logic [LW-1:0] r_ilv11;
    logic [LW-1:0] r_ilv21;
    logic [LW-1:0] r_ins;

    lmx_interleave #(.LW(LW)) u_ilv (
        .src_a (src_a),
        .src_b (src_b),
        .ilv11 (r_ilv11),
        .ilv21 (r_ilv21)
    );

    lmx_field_insert #(.LW(LW)) u_ins (
        .src    (src_a),
        .dst    (dst),
        .rot    (rot),
        .lo     (lo),
        .hi     (hi),
        .merged (r_ins)
    );

    // Opcode selects the lane result.
    always_comb begin
        unique case (op)
            MIX_ILV11:  res = r_ilv11;
            MIX_ILV21:  res = r_ilv21;
            MIX_INSERT: res = r_ins;
            default:    res = dst;
        endcase
    end

endmodule

// File: rtl/lane_bitmix.sv
// Top of the lane bit-mix unit: LANES parallel lanes and one result register.
// Assumes operands are valid at every clock edge; latency is one cycle.
module lane_bitmix
    import lane_bitmix_pkg::*;
#(
    parameter  int LANES = 16,
    parameter  int LW    = 32,
    localparam int SHW   = $clog2(LW),
    localparam int VW    = LANES * LW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     op_i,
    input  logic [VW-1:0]  src_a_i,
    input  logic [VW-1:0]  src_b_i,
    input  logic [VW-1:0]  dst_i,
    input  logic [SHW-1:0] rot_i,
    input  logic [SHW-1:0] lo_i,
    input  logic [SHW-1:0] hi_i,
    output logic [VW-1:0]  res_o
);
    logic [VW-1:0] lane_res;
    mix_op_e       op;

    assign op = mix_op_e'(op_i);

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            lmx_lane #(.LW(LW)) u_lane (
                .op    (op),
                .src_a (src_a_i[l*LW +: LW]),
                .src_b (src_b_i[l*LW +: LW]),
                .dst   (dst_i[l*LW +: LW]),
                .rot   (rot_i),
                .lo    (lo_i),
                .hi    (hi_i),
                .res   (lane_res[l*LW +: LW])
            );
        end
    endgenerate

    // Result register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) res_o <= '0;
        else        res_o <= lane_res;
    end

endmodule

// File: rtl/lane_bitmix_chk.sv
// Property checker for lane_bitmix, attached by bind.
// Assumes default lane layout; checks lane 0 bit patterns and whole-vector rules.
module lane_bitmix_chk #(
    parameter  int LANES = 16,
    parameter  int LW    = 32,
    localparam int SHW   = $clog2(LW),
    localparam int VW    = LANES * LW
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     op_i,
    input logic [VW-1:0]  src_a_i,
    input logic [VW-1:0]  src_b_i,
    input logic [VW-1:0]  dst_i,
    input logic [SHW-1:0] rot_i,
    input logic [SHW-1:0] lo_i,
    input logic [SHW-1:0] hi_i,
    input logic [VW-1:0]  res_o
);
    logic armed;

    // Set once a full cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    function automatic logic [VW-1:0] rot_all(input logic [VW-1:0] v, input logic [SHW-1:0] r);
        logic [VW-1:0] o;
        o = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int k = 0; k < LW; k++) begin
                o[l*LW + ((k + int'(r)) % LW)] = v[l*LW + k];
            end
        end
        return o;
    endfunction

    p_pass_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == 2'd0) |-> (res_o == $past(dst_i)));

    p_pair_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == 2'd1) |-> (res_o[1:0] == {$past(src_a_i[0]), $past(src_b_i[0])}));

    p_triple_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == 2'd2) |->
        (res_o[2:0] == {$past(src_a_i[1]), $past(src_a_i[0]), $past(src_b_i[0])}));

    p_empty_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == 2'd3 && $past(lo_i) > $past(hi_i)) |-> (res_o == $past(dst_i)));

    p_full_rotate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == 2'd3 && $past(lo_i) == '0 && $past(hi_i) == SHW'(LW-1)) |->
        (res_o == rot_all($past(src_a_i), $past(rot_i))));

endmodule

bind lane_bitmix lane_bitmix_chk #(.LANES(LANES), .LW(LW)) u_chk (.*);

// File: tb/lane_bitmix_test.sv
module lane_bitmix_test;
    localparam int LANES = 16;
    localparam int LW    = 32;
    localparam int VW    = LANES * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op_i = '0;
    logic [VW-1:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
    logic [4:0]    rot_i = '0, lo_i = '0, hi_i = '0;
    logic [VW-1:0] res_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lane_bitmix uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
        .rot_i(rot_i), .lo_i(lo_i), .hi_i(hi_i), .res_o(res_o)
    );

    function automatic logic [31:0] m_pair(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            r[2*i]   = b[i];
            r[2*i+1] = a[i];
        end
        return r;
    endfunction

    function automatic logic [31:0] m_triple(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r = '0;
        for (int i = 0; i < 11; i++) begin
            r[3*i] = b[i];
            if (3*i+1 < 32) r[3*i+1] = a[2*i];
            if (3*i+2 < 32) r[3*i+2] = a[2*i+1];
        end
        return r;
    endfunction

    function automatic logic [31:0] m_insert(input logic [31:0] a, input logic [31:0] d,
                                             input int r, input int lo, input int hi);
        logic [31:0] rr = '0;
        logic [31:0] o;
        for (int k = 0; k < 32; k++) rr[(k + r) % 32] = a[k];
        o = d;
        for (int k = 0; k < 32; k++) if (k >= lo && k <= hi) o[k] = rr[k];
        return o;
    endfunction

    function automatic logic [VW-1:0] m_vec(input int op, input logic [VW-1:0] a,
                                            input logic [VW-1:0] b, input logic [VW-1:0] d,
                                            input int r, input int lo, input int hi);
        logic [VW-1:0] o;
        for (int l = 0; l < LANES; l++) begin
            case (op)
                1:       o[l*32 +: 32] = m_pair(a[l*32 +: 32], b[l*32 +: 32]);
                2:       o[l*32 +: 32] = m_triple(a[l*32 +: 32], b[l*32 +: 32]);
                3:       o[l*32 +: 32] = m_insert(a[l*32 +: 32], d[l*32 +: 32], r, lo, hi);
                default: o[l*32 +: 32] = d[l*32 +: 32];
            endcase
        end
        return o;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int l = 0; l < LANES; l++) v[l*32 +: 32] = $urandom();
        return v;
    endfunction

    task automatic check(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            for (int l = 0; l < LANES; l++) begin
                if (got[l*32 +: 32] !== exp[l*32 +: 32]) begin
                    $display("FAIL %s lane %0d: got %h expected %h", tag, l,
                             got[l*32 +: 32], exp[l*32 +: 32]);
                    break;
                end
            end
        end
    endtask

    // Drive at a negedge, wait one cycle, compare at the next negedge.
    task automatic step(input string tag, input int op, input logic [VW-1:0] a,
                        input logic [VW-1:0] b, input logic [VW-1:0] d,
                        input int r, input int lo, input int hi);
        op_i = 2'(op); src_a_i = a; src_b_i = b; dst_i = d;
        rot_i = 5'(r); lo_i = 5'(lo); hi_i = 5'(hi);
        @(negedge clk);
        check(tag, res_o, m_vec(op, a, b, d, r, lo, hi));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] a, b, d, a2, b2, x, y, mort, expo;
        void'($urandom(32'd20240917));

        // R1: reset holds zero despite busy inputs
        @(negedge clk);
        op_i = 2'd3; src_a_i = rnd_vec(); dst_i = rnd_vec(); hi_i = 5'd31;
        @(negedge clk); @(negedge clk);
        check("R1", res_o, '0);

        // R2: first cycle out of reset, pass copies destination
        d = rnd_vec();
        rst_n = 1'b1;
        step("R2", 0, rnd_vec(), rnd_vec(), d, 3, 1, 9);

        // R3 / R5 / R11: directed single-bit patterns in distinct lanes
        a = '0; b = '0;
        a[0*32 + 5] = 1'b1; b[3*32 + 15] = 1'b1; a[7*32 + 20] = 1'b1; b[15*32 + 10] = 1'b1;
        step("R3", 1, a, b, rnd_vec(), 0, 0, 0);
        step("R5", 2, a, b, rnd_vec(), 0, 0, 0);
        step("R11", 3, rnd_vec(), rnd_vec(), rnd_vec(), 7, 8, 23);

        // R4: upper source bits do not matter for pair interleave
        a = rnd_vec(); b = rnd_vec(); a2 = a; b2 = b;
        for (int l = 0; l < LANES; l++) begin
            a2[l*32+16 +: 16] = '0; b2[l*32+16 +: 16] = '0;
        end
        step("R4", 1, a, b, rnd_vec(), 0, 0, 0);
        step("R4", 1, a2, b2, rnd_vec(), 0, 0, 0);

        // R6: upper source bits do not matter for triple interleave
        a2 = a; b2 = b;
        for (int l = 0; l < LANES; l++) begin
            a2[l*32+21 +: 11] = '1; b2[l*32+11 +: 21] = '0;
        end
        step("R6", 2, a, b, rnd_vec(), 0, 0, 0);
        step("R6", 2, a2, b2, rnd_vec(), 0, 0, 0);

        // R7 / R8: single-bit field, rotate zero, top bit with wrap
        step("R7", 3, rnd_vec(), rnd_vec(), rnd_vec(), 0, 12, 12);
        step("R7", 3, rnd_vec(), rnd_vec(), rnd_vec(), 31, 0, 0);
        step("R8", 3, rnd_vec(), rnd_vec(), rnd_vec(), 17, 31, 31);

        // R9: empty field leaves destination
        step("R9", 3, rnd_vec(), rnd_vec(), rnd_vec(), 9, 20, 19);
        step("R9", 3, rnd_vec(), rnd_vec(), rnd_vec(), 1, 31, 0);

        // R10: full-word field is a rotate
        step("R10", 3, rnd_vec(), rnd_vec(), rnd_vec(), 13, 0, 31);
        step("R10", 3, rnd_vec(), rnd_vec(), '1, 0, 0, 31);

        // R12: two-step texture offset, coordinates with garbage upper bits
        x = rnd_vec(); y = rnd_vec();
        op_i = 2'd1; src_a_i = y; src_b_i = x; dst_i = rnd_vec();
        @(negedge clk);
        mort = res_o;
        op_i = 2'd3; src_a_i = mort; dst_i = '0; rot_i = 5'd4; lo_i = 5'd4; hi_i = 5'd19;
        @(negedge clk);
        expo = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int i = 0; i < 8; i++) begin
                expo[l*32 + 4 + 2*i] = x[l*32 + i];
                expo[l*32 + 5 + 2*i] = y[l*32 + i];
            end
        end
        check("R12", res_o, expo);

        // Mixed random traffic across all opcodes (R2 R3 R5 R7 R8 R11)
        for (int n = 0; n < 300; n++) begin
            int op, r, lo, hi;
            op = int'($urandom_range(0, 3));
            r  = int'($urandom_range(0, 31));
            lo = int'($urandom_range(0, 31));
            hi = int'($urandom_range(0, 31));
            step(op == 0 ? "R2" : op == 1 ? "R3" : op == 2 ? "R5" : "R8",
                 op, rnd_vec(), rnd_vec(), rnd_vec(), r, lo, hi);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule